// File: doc/BRIEF.md
# Pulse-Distance Infrared Frame Decoder

This block turns one sampled infrared receiver line into decoded remote-control events. It times only the transitions onto the active level and measures each gap between two such transitions in sample clocks. Each gap is then classified as a leader, a repeat marker, a data 0 or a data 1. The sample rate is a compile-time parameter, and every nominal gap is converted from microseconds into a sample count.

After a leader, the decoder collects a 16-bit address word and then a 16-bit command word. Bits arrive first-in at the most significant end. Each word holds a value byte (upper) and a check byte (lower). A word passes when the bitwise AND of the two bytes is zero. Results are one-cycle pulses: leader, repeat, address valid with its byte, command valid with its byte, and error with a 16-bit word. The input is expected to be already demodulated and synchronised to the clock.

Top module: `ir_pd_decoder`

## Requirements
- R1: Only a transition onto the active level is an event; with `ACTIVE_LOW=1` that is a 1-to-0 change, with `ACTIVE_LOW=0` a 0-to-1 change. Returns to the inactive level, and where they fall, have no effect.
- R2: The interval of an event is the number of clock samples since the previous event (or since reset). A class with nominal time T µs has nominal count N = SAMPLE_HZ·T/10^6 − 1 and margin M = SAMPLE_HZ·100/10^6 − 1. The interval matches when N − M ≤ interval < N + M. The times are: leader 13500, repeat 11250, data 0 1125, data 1 2250.
- R3: In idle, a leader-length interval produces a `leader_o` pulse in the cycle after the event and starts address collection.
- R4: In idle, a repeat-length interval produces a `repeat_o` pulse and stays idle; any other interval in idle produces no output.
- R5: In address or command collection, a data-0 interval appends bit 0 and a data-1 interval appends bit 1. The first bit received ends up at bit 15 of the word.
- R6: On the 16th address bit, the word is checked. If (word[15:8] & word[7:0]) == 0, `addr_vld_o` pulses with `addr_byte_o` = word[15:8] and command collection starts. Otherwise `err_o` pulses with `err_word_o` = word and the decoder goes idle.
- R7: On the 16th command bit, the same check applies. On a pass, `cmd_vld_o` pulses with `cmd_byte_o` = word[15:8]; on a fail, `err_o` pulses with the word. In both cases the decoder then goes idle.
- R8: During collection, an interval matching neither data window pulses `err_o` and returns the decoder to idle. `err_word_o` then holds the bits collected so far, right-aligned (the latest bit at bit 0).
- R9: The interval counter saturates, so an arbitrarily long gap never aliases into a valid window.
- R10: While `rst_ni` is low, and until an event is decoded, all outputs are zero and the decoder is idle.
- R11: At most one of the five pulse outputs is high in any cycle. `addr_byte_o`, `cmd_byte_o` and `err_word_o` are zero whenever their own pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ir_i | input | 1 | Demodulated receiver line |
| leader_o | output | 1 | Leader interval decoded |
| repeat_o | output | 1 | Repeat interval decoded |
| addr_vld_o | output | 1 | Address word passed its check |
| addr_byte_o | output | 8 | Address value byte |
| cmd_vld_o | output | 1 | Command word passed its check |
| cmd_byte_o | output | 8 | Command value byte |
| err_o | output | 1 | Check failure or bad data interval |
| err_word_o | output | 16 | Word that failed, or the partial word on an abort |

## Verification
Frames with nominal timing and a passing address and command show the full leader-to-command path and the MSB-first bit order. Frames with a failing address or command show which field gates the sequence. Intervals placed at the lower bound, at the upper bound minus one and at the upper bound of each window separate an inclusive edge from an exclusive one. Other patterns cover the remaining cases:
- A lone repeat marker, and a bad interval in mid-address that must yield a right-aligned partial word.
- A gap longer than the counter range, followed by bit-length intervals, which shows that a wrapping counter would falsely start a frame.
- An active-high copy driven with the inverted line, together with a change in mark width, which shows that only transitions onto the active level are timed.

// File: rtl/ir_pd_pkg.sv
package ir_pd_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_CMD} frame_st_e;
  typedef enum logic [2:0] {SYM_NONE, SYM_LEAD, SYM_REP, SYM_ZERO, SYM_ONE} sym_e;

  // nominal sample count for a duration in microseconds
  function automatic int ticks(int rate_hz, int dur_us);
    longint t;
    t = longint'(rate_hz) * longint'(dur_us) / 64'sd1000000;
    return int'(t) - 1;
  endfunction
endpackage

// File: rtl/ir_pd_edge.sv
module ir_pd_edge #(
  parameter bit ACTIVE_LOW = 1'b1,
  parameter int CNT_W      = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ir_i,
  output logic             edge_o,
  output logic [CNT_W-1:0] ivl_o
);
  localparam logic ACT_LVL = ACTIVE_LOW ? 1'b0 : 1'b1;

  logic             prev_q;
  logic [CNT_W-1:0] cnt_q;

  assign edge_o = (ir_i == ACT_LVL) && (prev_q != ACT_LVL);
  assign ivl_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= ~ACT_LVL;
      cnt_q  <= '0;
    end else begin
      prev_q <= ir_i;
      if (edge_o)          cnt_q <= CNT_W'(1);
      else if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1); // saturate
    end
  end
endmodule

// File: rtl/ir_pd_classify.sv
module ir_pd_classify
  import ir_pd_pkg::*;
#(
  parameter int CNT_W  = 11,
  parameter int LEAD_T = 1349,
  parameter int REP_T  = 1124,
  parameter int ZERO_T = 111,
  parameter int ONE_T  = 224,
  parameter int MARG_T = 9
) (
  input  logic [CNT_W-1:0] ivl_i,
  output sym_e             sym_o
);
  function automatic logic in_win(int v, int nom);
    return (v >= nom - MARG_T) && (v < nom + MARG_T);
  endfunction

  int ivl;
  assign ivl = int'({1'b0, ivl_i});

  always_comb begin
    if      (in_win(ivl, LEAD_T)) sym_o = SYM_LEAD;
    else if (in_win(ivl, REP_T))  sym_o = SYM_REP;
    else if (in_win(ivl, ONE_T))  sym_o = SYM_ONE;
    else if (in_win(ivl, ZERO_T)) sym_o = SYM_ZERO;
    else                          sym_o = SYM_NONE;
  end
endmodule

// File: rtl/ir_pd_frame.sv
module ir_pd_frame
  import ir_pd_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                edge_i,
  input  sym_e                sym_i,
  output logic                leader_o,
  output logic                repeat_o,
  output logic                addr_vld_o,
  output logic [BYTE_W-1:0]   addr_byte_o,
  output logic                cmd_vld_o,
  output logic [BYTE_W-1:0]   cmd_byte_o,
  output logic                err_o,
  output logic [2*BYTE_W-1:0] err_word_o
);
  localparam int WORD_W = 2 * BYTE_W;
  localparam int BCNT_W = $clog2(WORD_W);

  frame_st_e          st_q, st_d;
  logic [WORD_W-1:0]  data_q, data_d, word;
  logic [BCNT_W-1:0]  bcnt_q, bcnt_d;
  logic               lead_d, rep_d, av_d, cv_d, er_d;
  logic [BYTE_W-1:0]  ab_d, cb_d;
  logic [WORD_W-1:0]  ew_d;
  logic               is_bit, field_ok;

  assign is_bit   = (sym_i == SYM_ZERO) || (sym_i == SYM_ONE);
  assign word     = {data_q[WORD_W-2:0], sym_i == SYM_ONE};
  assign field_ok = (word[WORD_W-1:BYTE_W] & word[BYTE_W-1:0]) == '0;

  always_comb begin
    st_d   = st_q;
    data_d = data_q;
    bcnt_d = bcnt_q;
    lead_d = 1'b0; rep_d = 1'b0; av_d = 1'b0; cv_d = 1'b0; er_d = 1'b0;
    ab_d   = '0;   cb_d  = '0;   ew_d = '0;
    if (edge_i) begin
      unique case (st_q)
        ST_IDLE: begin
          if (sym_i == SYM_LEAD) begin
            lead_d = 1'b1; data_d = '0; bcnt_d = '0; st_d = ST_ADDR;
          end else if (sym_i == SYM_REP) begin
            rep_d = 1'b1; data_d = '0; bcnt_d = '0;
          end
        end
        ST_ADDR, ST_CMD: begin
          if (!is_bit) begin
            er_d = 1'b1; ew_d = data_q; data_d = '0; bcnt_d = '0; st_d = ST_IDLE;
          end else if (bcnt_q == BCNT_W'(WORD_W - 1)) begin
            data_d = '0; bcnt_d = '0;
            if (!field_ok) begin
              er_d = 1'b1; ew_d = word; st_d = ST_IDLE;
            end else if (st_q == ST_ADDR) begin
              av_d = 1'b1; ab_d = word[WORD_W-1:BYTE_W]; st_d = ST_CMD;
            end else begin
              cv_d = 1'b1; cb_d = word[WORD_W-1:BYTE_W]; st_d = ST_IDLE;
            end
          end else begin
            data_d = word; bcnt_d = bcnt_q + BCNT_W'(1);
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE; data_q <= '0; bcnt_q <= '0;
      leader_o <= 1'b0; repeat_o <= 1'b0; addr_vld_o <= 1'b0; cmd_vld_o <= 1'b0;
      err_o <= 1'b0; addr_byte_o <= '0; cmd_byte_o <= '0; err_word_o <= '0;
    end else begin
      st_q <= st_d; data_q <= data_d; bcnt_q <= bcnt_d;
      leader_o <= lead_d; repeat_o <= rep_d; addr_vld_o <= av_d; cmd_vld_o <= cv_d;
      err_o <= er_d; addr_byte_o <= ab_d; cmd_byte_o <= cb_d; err_word_o <= ew_d;
    end
  end
endmodule

// File: rtl/ir_pd_decoder.sv
module ir_pd_decoder
  import ir_pd_pkg::*;
#(
  parameter int SAMPLE_HZ  = 100000,
  parameter bit ACTIVE_LOW = 1'b1,
  parameter int BYTE_W     = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ir_i,
  output logic                leader_o,
  output logic                repeat_o,
  output logic                addr_vld_o,
  output logic [BYTE_W-1:0]   addr_byte_o,
  output logic                cmd_vld_o,
  output logic [BYTE_W-1:0]   cmd_byte_o,
  output logic                err_o,
  output logic [2*BYTE_W-1:0] err_word_o
);
  localparam int LEAD_T = ticks(SAMPLE_HZ, 13500);
  localparam int REP_T  = ticks(SAMPLE_HZ, 11250);
  localparam int ZERO_T = ticks(SAMPLE_HZ, 1125);
  localparam int ONE_T  = ticks(SAMPLE_HZ, 2250);
  localparam int MARG_T = ticks(SAMPLE_HZ, 100);
  localparam int CNT_W  = $clog2(LEAD_T + MARG_T + 2);

  logic             edge_w;
  logic [CNT_W-1:0] ivl_w;
  sym_e             sym_w;

  ir_pd_edge #(.ACTIVE_LOW(ACTIVE_LOW), .CNT_W(CNT_W)) u_edge (
    .clk_i(clk_i), .rst_ni(rst_ni), .ir_i(ir_i), .edge_o(edge_w), .ivl_o(ivl_w)
  );

  ir_pd_classify #(
    .CNT_W(CNT_W), .LEAD_T(LEAD_T), .REP_T(REP_T),
    .ZERO_T(ZERO_T), .ONE_T(ONE_T), .MARG_T(MARG_T)
  ) u_cls (
    .ivl_i(ivl_w), .sym_o(sym_w)
  );

  ir_pd_frame #(.BYTE_W(BYTE_W)) u_frame (
    .clk_i(clk_i), .rst_ni(rst_ni), .edge_i(edge_w), .sym_i(sym_w),
    .leader_o(leader_o), .repeat_o(repeat_o),
    .addr_vld_o(addr_vld_o), .addr_byte_o(addr_byte_o),
    .cmd_vld_o(cmd_vld_o), .cmd_byte_o(cmd_byte_o),
    .err_o(err_o), .err_word_o(err_word_o)
  );
endmodule

// File: rtl/ir_pd_decoder_chk.sv
module ir_pd_decoder_chk #(
  parameter bit ACTIVE_LOW = 1'b1,
  parameter int BYTE_W     = 8
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                ir_i,
  input logic                leader_o,
  input logic                repeat_o,
  input logic                addr_vld_o,
  input logic [BYTE_W-1:0]   addr_byte_o,
  input logic                cmd_vld_o,
  input logic [BYTE_W-1:0]   cmd_byte_o,
  input logic                err_o,
  input logic [2*BYTE_W-1:0] err_word_o
);
  localparam logic ACT_LVL = ACTIVE_LOW ? 1'b0 : 1'b1;

  logic prev_q, in_lead_q, in_cmd_q, ev, any_pulse;
  assign ev        = (ir_i == ACT_LVL) && (prev_q != ACT_LVL);
  assign any_pulse = leader_o | repeat_o | addr_vld_o | cmd_vld_o | err_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= ~ACT_LVL; in_lead_q <= 1'b0; in_cmd_q <= 1'b0;
    end else begin
      prev_q <= ir_i;
      if (leader_o)                           in_lead_q <= 1'b1;
      else if (addr_vld_o || err_o)           in_lead_q <= 1'b0;
      if (addr_vld_o)                         in_cmd_q  <= 1'b1;
      else if (cmd_vld_o || err_o || leader_o) in_cmd_q <= 1'b0;
    end
  end

  AST_PULSE_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({leader_o, repeat_o, addr_vld_o, cmd_vld_o, err_o})); // R11
  AST_DATA_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!addr_vld_o |-> addr_byte_o == '0) and (!cmd_vld_o |-> cmd_byte_o == '0)
    and (!err_o |-> err_word_o == '0)); // R11
  AST_PULSE_AFTER_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_pulse |-> $past(ev)); // R1
  AST_ADDR_AFTER_LEADER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_vld_o |-> in_lead_q); // R6
  AST_CMD_AFTER_ADDR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_vld_o |-> in_cmd_q); // R7
endmodule

bind ir_pd_decoder ir_pd_decoder_chk #(.ACTIVE_LOW(ACTIVE_LOW), .BYTE_W(BYTE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ir_i(ir_i),
  .leader_o(leader_o), .repeat_o(repeat_o),
  .addr_vld_o(addr_vld_o), .addr_byte_o(addr_byte_o),
  .cmd_vld_o(cmd_vld_o), .cmd_byte_o(cmd_byte_o),
  .err_o(err_o), .err_word_o(err_word_o)
);

// File: tb/tb_ir_pd_decoder.sv
module tb_ir_pd_decoder;
  localparam int HZ   = 100000;
  localparam int LEAD = HZ * 135 / 10000 - 1;  // 13.5 ms
  localparam int REP  = HZ * 1125 / 100000 - 1;
  localparam int ZERO = HZ * 1125 / 1000000 - 1;
  localparam int ONE  = HZ * 225 / 100000 - 1;
  localparam int MRG  = HZ / 10000 - 1;

  logic clk = 1'b0, rst_ni = 1'b0, ir_lo = 1'b1, ir_hi = 1'b0;
  always #5 clk = ~clk;

  logic l0, r0, a0, c0, e0, l1, r1, a1, c1, e1;
  logic [7:0] ab0, cb0, ab1, cb1;
  logic [15:0] ew0, ew1;

  ir_pd_decoder #(.SAMPLE_HZ(HZ), .ACTIVE_LOW(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .ir_i(ir_lo), .leader_o(l0), .repeat_o(r0),
    .addr_vld_o(a0), .addr_byte_o(ab0), .cmd_vld_o(c0), .cmd_byte_o(cb0),
    .err_o(e0), .err_word_o(ew0));
  ir_pd_decoder #(.SAMPLE_HZ(HZ), .ACTIVE_LOW(1'b0)) dut_ah (
    .clk_i(clk), .rst_ni(rst_ni), .ir_i(ir_hi), .leader_o(l1), .repeat_o(r1),
    .addr_vld_o(a1), .addr_byte_o(ab1), .cmd_vld_o(c1), .cmd_byte_o(cb1),
    .err_o(e1), .err_word_o(ew1));

  int vectors = 0, miscompares = 0, mark = 40;
  string req = "R10";
  bit done = 1'b0;

  // reference model state
  int m_st = 0, m_data = 0, m_nb = 0, m_ivl = 0;
  bit m_prev = 1'b0;
  bit x_l, x_r, x_a, x_c, x_e;
  int x_ab, x_cb, x_ew;

  function automatic bit win(int v, int nom);
    return v >= nom - MRG && v < nom + MRG;
  endfunction

  task automatic cmp1(string sig, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, sig, act, exp, $time);
    end
  endtask

  task automatic compare_all();
    cmp1("leader(R3)", l0, x_l);  cmp1("repeat(R4)", r0, x_r);
    cmp1("addr_vld(R6)", a0, x_a); cmp1("addr_byte(R6)", ab0, x_ab);
    cmp1("cmd_vld(R7)", c0, x_c);  cmp1("cmd_byte(R7)", cb0, x_cb);
    cmp1("err(R8)", e0, x_e);      cmp1("err_word(R8)", ew0, x_ew);
    cmp1("ah_leader(R1)", l1, x_l); cmp1("ah_repeat(R1)", r1, x_r);
    cmp1("ah_addr(R1)", {a1, ab1}, {x_a, x_ab[7:0]});
    cmp1("ah_cmd(R1)", {c1, cb1}, {x_c, x_cb[7:0]});
    cmp1("ah_err(R1)", {e1, ew1}, {x_e, x_ew[15:0]});
  endtask

  task automatic step(bit act);
    bit ev, b;
    int w;
    ir_lo = ~act; ir_hi = act;
    ev = act && !m_prev; m_prev = act;
    {x_l, x_r, x_a, x_c, x_e} = '0; x_ab = 0; x_cb = 0; x_ew = 0;
    if (ev) begin
      if (m_st == 0) begin
        if (win(m_ivl, LEAD)) begin x_l = 1; m_data = 0; m_nb = 0; m_st = 1; end
        else if (win(m_ivl, REP)) begin x_r = 1; m_data = 0; m_nb = 0; end
      end else begin
        if (win(m_ivl, ONE)) b = 1;
        else if (win(m_ivl, ZERO)) b = 0;
        else begin
          x_e = 1; x_ew = m_data; m_data = 0; m_nb = 0; m_st = 0;
        end
        if (m_st != 0) begin
          m_data = ((m_data << 1) | int'(b)) & 16'hffff;
          m_nb++;
          if (m_nb == 16) begin
            w = m_data; m_data = 0; m_nb = 0;
            if (((w >> 8) & w & 8'hff) != 0) begin x_e = 1; x_ew = w; m_st = 0; end
            else if (m_st == 1) begin x_a = 1; x_ab = w >> 8; m_st = 2; end
            else begin x_c = 1; x_cb = w >> 8; m_st = 0; end
          end
        end
      end
      m_ivl = 1;
    end else if (m_ivl < 100000000) m_ivl++;
    @(negedge clk);
    compare_all();
  endtask

  task automatic pulse(int n);
    for (int i = 0; i < mark; i++) step(1'b1);
    for (int i = mark; i < n; i++) step(1'b0);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic frame(int lead, logic [15:0] a, logic [15:0] c, int z, int o);
    pulse(lead);
    for (int i = 15; i >= 0; i--) pulse(a[i] ? o : z);
    for (int i = 15; i >= 0; i--) pulse(c[i] ? o : z);
    pulse(300);
    idle(200);
  endtask

  initial begin
    {x_l, x_r, x_a, x_c, x_e} = '0; x_ab = 0; x_cb = 0; x_ew = 0;
    // R10: outputs quiet in reset
    for (int i = 0; i < 4; i++) begin @(negedge clk); compare_all(); end
    rst_ni = 1'b1;
    req = "R10"; idle(50);
    req = "R6";  frame(LEAD, 16'h5AA5, 16'h3CC3, ZERO, ONE);  // R5 MSB-first, R7 pass
    req = "R4";  pulse(REP); pulse(300); idle(100);
    req = "R6";  frame(LEAD, 16'h1213, 16'h3CC3, ZERO, ONE);  // address check fails
    req = "R7";  frame(LEAD, 16'h00FF, 16'h8181, ZERO, ONE);  // command check fails
    req = "R2";  frame(LEAD - MRG, 16'hF00F, 16'h0FF0, ZERO - MRG, ONE + MRG - 1);
    req = "R2";  frame(LEAD + MRG - 1, 16'h01FE, 16'h40BF, ZERO + MRG - 1, ONE - MRG);
    req = "R2";  frame(LEAD + MRG, 16'h01FE, 16'h40BF, ZERO, ONE);  // leader too long
    req = "R4";  pulse(REP + MRG); pulse(REP - MRG); pulse(300); idle(100);
    req = "R8";  pulse(LEAD); pulse(ONE); pulse(ZERO); pulse(ONE + MRG); pulse(300); idle(100);
    req = "R8";  pulse(LEAD); pulse(ZERO + MRG); pulse(300); idle(100);
    req = "R9";  pulse(2048 + LEAD + 1);
    for (int i = 0; i < 16; i++) pulse(ONE);
    pulse(300); idle(100);
    req = "R1";  mark = 90;
    frame(LEAD, 16'h22DD, 16'h10EF, ZERO, ONE);
    mark = 40;
    req = "R3";  frame(LEAD, 16'h0000, 16'h0000, ZERO, ONE);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    #1900000;
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule